// File: doc/BRIEF.md
# Floppy Sector DMA Engine with Ping-Pong Packet Buffers

This block moves sector data between a byte-wide floppy controller port and main memory, so that the processor never has to copy bytes itself. Inside it are two 16-byte packet buffers that take turns. While one buffer exchanges bytes with the controller, the other moves to or from memory in a single burst. A burst runs on a 16-bit system bus once a bus request has been granted. The processor is held off for the length of the burst.

Software programs three things in one configuration write: a direction, a start address and a count of 512-byte sectors. That write also discards everything in flight. In the disk-to-memory direction, each controller byte goes into the filling buffer. A full buffer is written out as eight big-endian words. In the memory-to-disk direction, the engine fetches both buffers ahead of time and refetches each one as soon as the controller has drained it. The sector count drops by one for every 512 bytes that cross the bus. At zero the engine stops asking for the bus. A sticky error flag reports any controller request that finds no buffer ready.

Top module: `disk_dma_pingpong`

## Requirements
- R1: After reset, and after any configuration write, both buffers are empty, `bus_req` and `st_err` are low, the address is the loaded value, and the sector count is the loaded value (0 after reset, so `st_cnt_zero` is high).
- R2: With `cfg_to_disk`=0, each `fdc_req` cycle stores `fdc_wdata` into the filling buffer. After the 16th byte of a buffer, `bus_req` rises without any further stimulus.
- R3: During a burst, one 16-bit word moves on every cycle in which `mem_strobe` is high. `mem_we` is 1 for disk-to-memory and 0 for memory-to-disk. The earlier byte of each pair sits in bits 15:8. `mem_addr` advances by 2 after each word and holds otherwise.
- R4: `bus_req` stays high until it is granted. No word moves (`mem_strobe` low) and the address holds while `bus_grant` is low.
- R5: With no grant, the controller can fill both buffers (32 bytes) without raising an error.
- R6: With `cfg_to_disk`=1 and a nonzero count, the engine fills both buffers from memory (32 bytes, address +32) before the controller asks for any byte. After that it drops `bus_req`.
- R7: In memory-to-disk mode, `fdc_rdata` presents the bytes in memory order, one per `fdc_req`. A drained buffer is refetched in time, so a controller paced at one byte per two cycles or slower never underruns.
- R8: The sector count decrements once per 512 bytes moved on the bus. `st_cnt_zero` is high when the count is 0, and no bus request is raised while the count is 0.
- R9: `st_err` is set when `fdc_req` arrives with no buffer ready. The rejected byte is dropped, or in memory-to-disk mode the read position is not advanced. The flag stays set until the next configuration write.
- R10: A configuration write in the middle of a partly filled buffer discards that data. The next bytes start a fresh buffer at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe; loads the fields below and clears all state |
| cfg_to_disk | input | 1 | Direction: 1 memory-to-disk, 0 disk-to-memory |
| cfg_blocks | input | CNT_W | Number of 512-byte sectors to move |
| cfg_addr | input | ADDR_W | Start byte address (even) |
| st_err | output | 1 | Sticky error: controller request with no buffer ready |
| st_cnt_zero | output | 1 | Sector count is zero |
| fdc_req | input | 1 | Controller data request, one byte per cycle high |
| fdc_wdata | input | 8 | Byte from controller (disk-to-memory) |
| fdc_rdata | output | 8 | Byte to controller (memory-to-disk), valid in the request cycle |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant |
| mem_strobe | output | 1 | A word moves this cycle |
| mem_we | output | 1 | Word cycle is a write to memory |
| mem_addr | output | ADDR_W | Byte address of the current word |
| mem_wdata | output | 16 | Word to memory |
| mem_rdata | input | 16 | Word from memory, valid in the strobe cycle |

## Verification
The bench holds the grant off to fill both packets and then forces an overrun. An engine without a second buffer, or one that flags errors too early, would raise the error at byte 17 rather than byte 33. It then checks that the dropped byte never reaches memory. A full-sector run in each direction, with random grant latency and random controller pacing, catches byte-swapped words, address steps other than 2 and refetches that arrive too late. After the count reaches zero, the bench keeps pushing and pulling. A design that goes on requesting the bus would move the address or clear the full flags. A configuration write after ten bytes must realign the next packet. Stale index state would shift every word at the new address.

// File: rtl/disk_dma_pingpong.sv
module disk_dma_pingpong #(
  parameter int ADDR_W       = 24,
  parameter int BUF_BYTES    = 16,
  parameter int SECTOR_BYTES = 512,
  parameter int CNT_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_to_disk,
  input  logic [CNT_W-1:0]  cfg_blocks,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic              st_err,
  output logic              st_cnt_zero,
  input  logic              fdc_req,
  input  logic [7:0]        fdc_wdata,
  output logic [7:0]        fdc_rdata,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              mem_strobe,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);

  localparam int IDX_W  = $clog2(BUF_BYTES);
  localparam int WORDS  = BUF_BYTES / 2;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int PKTS   = SECTOR_BYTES / BUF_BYTES;
  localparam int PKT_W  = $clog2(PKTS);
  localparam logic [IDX_W-1:0]  LAST_BYTE = IDX_W'(BUF_BYTES - 1);
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(WORDS - 1);
  localparam logic [PKT_W-1:0]  LAST_PKT  = PKT_W'(PKTS - 1);

  logic              to_disk;
  logic [CNT_W-1:0]  blocks;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        bufm [2][BUF_BYTES];
  logic [1:0]        full;
  logic              fsel, bsel, busy, err;
  logic [IDX_W-1:0]  bidx;
  logic [WIDX_W-1:0] widx;
  logic [PKT_W-1:0]  pkt;

  wire fdc_ok    = to_disk ? full[fsel] : !full[fsel];
  wire bus_want  = (blocks != '0) && (to_disk ? !full[bsel] : full[bsel]);
  wire word_go   = busy && bus_grant;
  wire last_word = word_go && (widx == LAST_WORD);

  assign st_err      = err;
  assign st_cnt_zero = (blocks == '0);
  assign bus_req     = busy;
  assign mem_strobe  = word_go;
  assign mem_we      = !to_disk;
  assign mem_addr    = addr;
  assign mem_wdata   = {bufm[bsel][{widx, 1'b0}], bufm[bsel][{widx, 1'b1}]};
  assign fdc_rdata   = bufm[fsel][bidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_disk <= 1'b0;
      blocks  <= '0;
      addr    <= '0;
      full    <= '0;
      fsel    <= 1'b0;
      bsel    <= 1'b0;
      busy    <= 1'b0;
      err     <= 1'b0;
      bidx    <= '0;
      widx    <= '0;
      pkt     <= '0;
    end else if (cfg_we) begin
      to_disk <= cfg_to_disk;
      blocks  <= cfg_blocks;
      addr    <= cfg_addr;
      full    <= '0;
      fsel    <= 1'b0;
      bsel    <= 1'b0;
      busy    <= 1'b0;
      err     <= 1'b0;
      bidx    <= '0;
      widx    <= '0;
      pkt     <= '0;
    end else begin
      if (fdc_req) begin
        if (fdc_ok) begin
          bidx <= bidx + 1'b1;
          if (bidx == LAST_BYTE) begin
            full[fsel] <= !to_disk;
            fsel       <= !fsel;
          end
        end else begin
          err <= 1'b1;
        end
      end
      if (!busy && bus_want) busy <= 1'b1;
      if (word_go) begin
        addr <= addr + ADDR_W'(2);
        widx <= widx + 1'b1;
      end
      if (last_word) begin
        busy       <= 1'b0;
        full[bsel] <= to_disk;
        bsel       <= !bsel;
        pkt        <= (pkt == LAST_PKT) ? '0 : pkt + 1'b1;
        if (pkt == LAST_PKT) blocks <= blocks - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!cfg_we && fdc_req && fdc_ok && !to_disk)
      bufm[fsel][bidx] <= fdc_wdata;
    if (!cfg_we && word_go && to_disk) begin
      bufm[bsel][{widx, 1'b0}] <= mem_rdata[15:8];
      bufm[bsel][{widx, 1'b1}] <= mem_rdata[7:0];
    end
  end

  p_cfg_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !bus_req && !st_err);

  p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_grant && !cfg_we |=> bus_req);

  p_strobe_granted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_strobe |-> bus_grant && bus_req);

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_strobe && !cfg_we |=> mem_addr == $past(mem_addr) + ADDR_W'(2));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_strobe && !cfg_we |=> $stable(mem_addr));

  p_zero_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !$past(st_cnt_zero));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_err && !cfg_we |=> st_err);

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_strobe && !cfg_we |=> $stable(st_cnt_zero));

endmodule

// File: tb/test_disk_dma_pingpong.sv
module test_disk_dma_pingpong;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0, cfg_to_disk = 0;
  logic [7:0]  cfg_blocks = 0;
  logic [23:0] cfg_addr = 0;
  logic        st_err, st_cnt_zero;
  logic        fdc_req = 0;
  logic [7:0]  fdc_wdata = 0, fdc_rdata;
  logic        bus_req, bus_grant = 0, mem_strobe, mem_we;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  logic [15:0] mem [0:4095];
  logic [7:0]  exp_b [0:511];
  logic        auto_grant = 0;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  disk_dma_pingpong i_disk_dma_pingpong (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_to_disk(cfg_to_disk),
    .cfg_blocks(cfg_blocks), .cfg_addr(cfg_addr), .st_err(st_err),
    .st_cnt_zero(st_cnt_zero), .fdc_req(fdc_req), .fdc_wdata(fdc_wdata),
    .fdc_rdata(fdc_rdata), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_strobe(mem_strobe), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  assign mem_rdata = mem[mem_addr[12:1]];
  always @(posedge clk) if (mem_strobe && mem_we) mem[mem_addr[12:1]] <= mem_wdata;

  initial forever begin
    @(negedge clk);
    if (!bus_req) bus_grant = 0;
    else if (auto_grant && !bus_grant) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      bus_grant = auto_grant;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic configure(input logic dir, input logic [7:0] n, input logic [23:0] a);
    @(negedge clk);
    cfg_to_disk = dir; cfg_blocks = n; cfg_addr = a; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    fdc_wdata = b; fdc_req = 1;
    @(negedge clk);
    fdc_req = 0;
  endtask

  task automatic pull(output logic [7:0] b);
    @(negedge clk);
    fdc_req = 1;
    #1 b = fdc_rdata;
    @(negedge clk);
    fdc_req = 0;
  endtask

  function automatic logic [15:0] exp_word(input int k);
    return {exp_b[2*k], exp_b[2*k+1]};
  endfunction

  function automatic logic [7:0] mem_byte(input int base_w, input int k);
    logic [15:0] w;
    w = mem[base_w + k/2];
    return (k % 2 == 0) ? w[15:8] : w[7:0];
  endfunction

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed, bad;
    logic [7:0] b;
    seed = $urandom(32'h1d5e);
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 bus_req after reset", bus_req, 0);
    chk("R1 st_err after reset", st_err, 0);
    chk("R1 cnt_zero after reset", st_cnt_zero, 1);
    chk("R1 strobe after reset", mem_strobe, 0);

    // Disk to memory, grant withheld: both packets fill, then overrun
    configure(0, 1, 24'h100);
    chk("R1 address loaded", mem_addr, 24'h100);
    for (int i = 0; i < 16; i++) begin exp_b[i] = 8'($urandom); push(exp_b[i]); end
    repeat (3) @(negedge clk);
    chk("R2 bus_req after 16 bytes", bus_req, 1);
    chk("R4 no strobe without grant", mem_strobe, 0);
    for (int i = 16; i < 32; i++) begin exp_b[i] = 8'($urandom); push(exp_b[i]); end
    chk("R5 no error with 32 bytes held", st_err, 0);
    push(8'hEE);
    chk("R9 error on 33rd byte", st_err, 1);
    repeat (5) @(negedge clk);
    chk("R4 request held", bus_req, 1);
    chk("R4 address held", mem_addr, 24'h100);
    auto_grant = 1;
    repeat (40) @(negedge clk);
    chk("R2 request dropped after drain", bus_req, 0);
    bad = 0;
    for (int k = 0; k < 16; k++) if (mem[12'h80 + k] !== exp_word(k)) bad++;
    chk("R3 packet words in memory", bad, 0);
    chk("R3 address after two bursts", mem_addr, 24'h120);
    chk("R9 dropped byte not written", mem[12'h90], 16'h0);
    chk("R9 error still set", st_err, 1);

    // Full sector disk to memory with random grant latency
    configure(0, 1, 24'h200);
    chk("R1 error cleared by config", st_err, 0);
    chk("R8 count nonzero", st_cnt_zero, 0);
    for (int i = 0; i < 512; i++) begin
      exp_b[i] = 8'($urandom); push(exp_b[i]);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 256; k++) if (mem[12'h100 + k] !== exp_word(k)) bad++;
    chk("R2 R3 sector words in memory", bad, 0);
    chk("R8 count reached zero", st_cnt_zero, 1);
    chk("R3 address after sector", mem_addr, 24'h400);
    for (int i = 0; i < 32; i++) push(8'h5A);
    repeat (20) @(negedge clk);
    chk("R8 no request at zero", bus_req, 0);
    chk("R8 address frozen at zero", mem_addr, 24'h400);
    chk("R8 buffers fill without error", st_err, 0);
    push(8'h5A);
    chk("R9 overrun at zero count", st_err, 1);

    // Memory to disk: prefetch, then paced pull of a sector
    for (int i = 0; i < 256; i++) mem[12'h400 + i] = 16'($urandom);
    configure(1, 1, 24'h800);
    repeat (40) @(negedge clk);
    chk("R6 prefetch done, request dropped", bus_req, 0);
    chk("R6 prefetch address", mem_addr, 24'h820);
    chk("R6 no error during prefetch", st_err, 0);
    bad = 0;
    for (int k = 0; k < 512; k++) begin
      pull(b);
      if (b !== mem_byte(12'h400, k)) bad++;
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    chk("R7 bytes in memory order", bad, 0);
    chk("R7 no underrun", st_err, 0);
    chk("R8 count zero after sector", st_cnt_zero, 1);
    chk("R8 address after sector", mem_addr, 24'hA00);
    pull(b);
    chk("R9 request with empty buffers", st_err, 1);

    // Reconfigure mid-packet
    auto_grant = 0;
    configure(0, 1, 24'h300);
    for (int i = 0; i < 10; i++) push(8'hC3);
    configure(0, 1, 24'h300);
    chk("R10 error clear after reconfig", st_err, 0);
    for (int i = 0; i < 16; i++) begin exp_b[i] = 8'($urandom); push(exp_b[i]); end
    auto_grant = 1;
    repeat (30) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 8; k++) if (mem[12'h180 + k] !== exp_word(k)) bad++;
    chk("R10 fresh packet aligned", bad, 0);
    chk("R10 address after one packet", mem_addr, 24'h310);

    // Memory to disk, grant withheld
    auto_grant = 0;
    configure(1, 2, 24'h800);
    repeat (20) @(negedge clk);
    chk("R4 prefetch request waits", bus_req, 1);
    chk("R4 address waits", mem_addr, 24'h800);
    auto_grant = 1;
    repeat (40) @(negedge clk);
    chk("R6 prefetch after late grant", mem_addr, 24'h820);
    chk("R8 count two still nonzero", st_cnt_zero, 0);

    finish_run();
  end
endmodule